// File: doc/BRIEF.md
# Long Training Sequence Peak Pair Detector

This block watches a stream of cross-correlation magnitudes, one per valid sample, and confirms OFDM long-training timing. A sample counts as a peak when its magnitude clears a correlation threshold. A second threshold marks each peak as big or small. A detection is declared when two peaks are a permitted number of samples apart. The permitted spacings are 63, 64 and 65 samples, and each is enabled by its own mask bit.

An upstream packet-detect pulse arms the block and starts a timeout window. A valid pair found while the block is armed gives a success pulse. If the window runs out first, a timeout pulse is given instead. When the block is not armed, a pair either starts a reception on its own (LTF-only) or is ignored, depending on a configuration bit. LTF-only starts are counted in a 32-bit counter, which a stats-clear input resets.

Top module: `lts_pair_detector`

## Requirements
- R1: A valid sample is a peak only when `corr_mag` is strictly greater than `corr_thresh`. A magnitude equal to the threshold is not a peak.
- R2: A peak is big when `corr_mag` is strictly greater than `class_thresh`, and small otherwise. On a success pulse, `first_big` carries the class of the reference peak and `second_big` the class of the closing peak. Both hold their values until the next success.
- R3: Separation is counted in valid samples (`sample_vld` high). A pair at separation 63, 64 or 65 is accepted only when mask bit 0, 1 or 2 respectively is set. Any combination of bits may be set.
- R4: A peak that does not close an accepted pair becomes the new reference. A peak more than 65 samples after the reference never pairs with it.
- R5: Let T be `timeout_len`. A `pkt_det` pulse arms the block and restarts the window; a valid sample in the same cycle counts as sample 1. If no pair is accepted by the 2*T-th valid sample, `timeout` pulses after that sample. T=0 times out on the first sample. A pair on the limit sample wins over the timeout.
- R6: `found` and `timeout` are single-cycle pulses, registered one clock after the deciding sample. After either pulse the block is idle: disarmed, with no reference peak.
- R7: With `req_pkt_det`=1, a pair found while not armed gives no `found`. Its closing peak becomes the reference.
- R8: With `req_pkt_det`=0, a pair found while not armed gives `found` and `ltf_only` in the same cycle.
- R9: `ltf_count` (32 bits, wrapping) increments on the same edge that raises `ltf_only`. `stats_clr` sets it to zero on the next edge and takes priority over an increment in that cycle.
- R10: After reset, `found`, `timeout`, `ltf_only`, `first_big`, `second_big` and `ltf_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | Current correlation sample is valid |
| corr_mag | input | 16 | Correlation magnitude |
| corr_thresh | input | 16 | Peak threshold |
| class_thresh | input | 16 | Big/small threshold |
| spacing_mask | input | 3 | Permitted spacings: bit0=63, bit1=64, bit2=65 |
| timeout_len | input | 8 | Search window in units of 2 samples |
| req_pkt_det | input | 1 | Ignore pairs found without a prior packet detect |
| pkt_det | input | 1 | Upstream packet-detect pulse |
| stats_clr | input | 1 | Clear the LTF-only counter |
| found | output | 1 | Success pulse |
| timeout | output | 1 | Search timeout pulse |
| ltf_only | output | 1 | Success came from an unarmed (LTF-only) pair |
| first_big | output | 1 | Class of the reference peak of the last pair |
| second_big | output | 1 | Class of the closing peak of the last pair |
| ltf_count | output | 32 | Count of LTF-only starts |

## Verification
The properties assume that `pkt_det` is a single-cycle pulse. They also assume the thresholds, mask and timeout length stay constant while a reference peak is held, so that the pair event seen one cycle earlier still explains the pulse. The bench changes configuration only between scenarios. Before arming, each scenario first ages out any stale reference with a run of low samples. It keeps `pkt_det` away from sample cycles, except in the deliberate zero-length timeout case.

// File: rtl/lts_pkg.sv
package lts_pkg;
  parameter int LTS_MASK_W   = 3;
  parameter int LTS_SEP_BASE = 63;
  parameter int LTS_SEP_W    = 7;
  parameter int LTS_TMO_W    = 8;

  typedef struct packed {
    logic peak;
    logic big;
  } lts_peak_t;

  // separation is allowed when its mask bit is set (bit i -> base + i)
  function automatic logic spacing_ok(input logic [LTS_SEP_W:0] sep,
                                      input logic [LTS_MASK_W-1:0] mask);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < LTS_MASK_W; i++) begin
      if (mask[i] && sep == (LTS_SEP_W+1)'(LTS_SEP_BASE + i)) ok = 1'b1;
    end
    return ok;
  endfunction

  // window length in samples: two samples per unit
  function automatic logic [LTS_TMO_W:0] tmo_limit(input logic [LTS_TMO_W-1:0] units);
    return {units, 1'b0};
  endfunction
endpackage

// File: rtl/lts_peak_classify.sv
module lts_peak_classify #(
  parameter int MAG_W = 16
) (
  input  logic [MAG_W-1:0]      mag,
  input  logic [MAG_W-1:0]      peak_thr,
  input  logic [MAG_W-1:0]      big_thr,
  output lts_pkg::lts_peak_t    pk
);
  always_comb begin
    pk.peak = mag > peak_thr;
    pk.big  = mag > big_thr;
  end
endmodule

// File: rtl/lts_pair_tracker.sv
module lts_pair_tracker
  import lts_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_vld,
  input  lts_peak_t             pk,
  input  logic                  pkt_det,
  input  logic                  req_pkt_det,
  input  logic [LTS_MASK_W-1:0] spacing_mask,
  input  logic [LTS_TMO_W-1:0]  timeout_len,
  output logic                  pair_hit,
  output logic                  armed_eff,
  output logic                  ltf_evt,
  output logic                  found,
  output logic                  timeout,
  output logic                  ltf_only,
  output logic                  first_big,
  output logic                  second_big
);
  localparam int TW = LTS_TMO_W + 1;

  logic                 have_ref_q, armed_q, ref_big_q;
  logic [LTS_SEP_W-1:0] dist_q;
  logic [TW-1:0]        timer_q, timer_eff, timer_inc;
  logic [LTS_SEP_W:0]   sep;
  logic                 accept, tmo_hit;

  always_comb begin
    armed_eff = armed_q | pkt_det;
    timer_eff = pkt_det ? '0 : timer_q;
    timer_inc = timer_eff + 1'b1;
    sep       = {1'b0, dist_q} + 1'b1;
    pair_hit  = sample_vld & have_ref_q & pk.peak & spacing_ok(sep, spacing_mask);
    accept    = pair_hit & (armed_eff | ~req_pkt_det);
    ltf_evt   = accept & ~armed_eff;
    tmo_hit   = sample_vld & armed_eff & ~accept & (timer_inc >= tmo_limit(timeout_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      armed_q    <= 1'b0;
      ref_big_q  <= 1'b0;
      dist_q     <= '0;
      timer_q    <= '0;
    end else if (accept || tmo_hit) begin
      have_ref_q <= 1'b0;
      armed_q    <= 1'b0;
      dist_q     <= '0;
      timer_q    <= '0;
    end else begin
      armed_q <= armed_eff;
      if (!armed_eff)     timer_q <= '0;
      else if (sample_vld) timer_q <= timer_inc;
      else                timer_q <= timer_eff;
      if (sample_vld && pk.peak) begin
        have_ref_q <= 1'b1;
        dist_q     <= '0;
        ref_big_q  <= pk.big;
      end else if (sample_vld && have_ref_q && dist_q != '1) begin
        dist_q <= dist_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found      <= 1'b0;
      timeout    <= 1'b0;
      ltf_only   <= 1'b0;
      first_big  <= 1'b0;
      second_big <= 1'b0;
    end else begin
      found    <= accept;
      timeout  <= tmo_hit;
      ltf_only <= ltf_evt;
      if (accept) begin
        first_big  <= ref_big_q;
        second_big <= pk.big;
      end
    end
  end
endmodule

// File: rtl/lts_event_counter.sv
module lts_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/lts_pair_detector.sv
module lts_pair_detector #(
  parameter int MAG_W = 16,
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sample_vld,
  input  logic [MAG_W-1:0]               corr_mag,
  input  logic [MAG_W-1:0]               corr_thresh,
  input  logic [MAG_W-1:0]               class_thresh,
  input  logic [lts_pkg::LTS_MASK_W-1:0] spacing_mask,
  input  logic [lts_pkg::LTS_TMO_W-1:0]  timeout_len,
  input  logic                           req_pkt_det,
  input  logic                           pkt_det,
  input  logic                           stats_clr,
  output logic                           found,
  output logic                           timeout,
  output logic                           ltf_only,
  output logic                           first_big,
  output logic                           second_big,
  output logic [CNT_W-1:0]               ltf_count
);
  lts_pkg::lts_peak_t pk;
  logic pair_hit, armed_eff, ltf_evt;

  lts_peak_classify #(.MAG_W(MAG_W)) u_cls (
    .mag(corr_mag), .peak_thr(corr_thresh), .big_thr(class_thresh), .pk(pk)
  );

  lts_pair_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .pk(pk),
    .pkt_det(pkt_det), .req_pkt_det(req_pkt_det), .spacing_mask(spacing_mask),
    .timeout_len(timeout_len), .pair_hit(pair_hit), .armed_eff(armed_eff),
    .ltf_evt(ltf_evt), .found(found), .timeout(timeout), .ltf_only(ltf_only),
    .first_big(first_big), .second_big(second_big)
  );

  lts_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(stats_clr), .inc(ltf_evt), .count(ltf_count)
  );
endmodule

// File: rtl/lts_pair_checker.sv
module lts_pair_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_vld,
  input logic             req_pkt_det,
  input logic             stats_clr,
  input logic             pair_hit,
  input logic             armed_eff,
  input logic             found,
  input logic             timeout,
  input logic             ltf_only,
  input logic [CNT_W-1:0] ltf_count
);
  assert_excl_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && timeout));
  assert_found_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found);
  assert_found_from_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> $past(pair_hit));
  assert_no_sample_no_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> (!found && !timeout));
  assert_timeout_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(armed_eff));
  assert_req_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_hit && req_pkt_det && !armed_eff) |=> !found);
  assert_ltf_with_found_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ltf_only |-> found);
  assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stats_clr |=> (ltf_count == '0));
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ltf_only && !$past(stats_clr)) |-> (ltf_count == $past(ltf_count) + 1'b1));
endmodule

bind lts_pair_detector lts_pair_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .req_pkt_det(req_pkt_det),
  .stats_clr(stats_clr), .pair_hit(pair_hit), .armed_eff(armed_eff),
  .found(found), .timeout(timeout), .ltf_only(ltf_only), .ltf_count(ltf_count)
);

// File: tb/tb_lts_pair_detector.sv
module tb_lts_pair_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_vld = 1'b0;
  logic [15:0] corr_mag = '0;
  logic [15:0] corr_thresh = 16'd500;
  logic [15:0] class_thresh = 16'd800;
  logic [2:0]  spacing_mask = 3'b001;
  logic [7:0]  timeout_len = 8'd255;
  logic        req_pkt_det = 1'b1;
  logic        pkt_det = 1'b0;
  logic        stats_clr = 1'b0;
  logic        found, timeout, ltf_only, first_big, second_big;
  logic [31:0] ltf_count;

  int checks = 0;
  int failures = 0;
  int stray = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lts_pair_detector dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .corr_mag(corr_mag),
    .corr_thresh(corr_thresh), .class_thresh(class_thresh),
    .spacing_mask(spacing_mask), .timeout_len(timeout_len),
    .req_pkt_det(req_pkt_det), .pkt_det(pkt_det), .stats_clr(stats_clr),
    .found(found), .timeout(timeout), .ltf_only(ltf_only),
    .first_big(first_big), .second_big(second_big), .ltf_count(ltf_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: optional sample, then outputs are read just after the edge
  task automatic step(input bit vld, input int mag, input bit det, input bit clr);
    @(negedge clk);
    sample_vld = vld;
    corr_mag   = 16'(mag);
    pkt_det    = det;
    stats_clr  = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic smp(input int mag, input bit det = 0, input bit clr = 0);
    step(1'b1, mag, det, clr);
  endtask

  task automatic arm();
    step(1'b0, 0, 1'b1, 1'b0);
  endtask

  task automatic lows(input int n);
    for (int i = 0; i < n; i++) begin
      smp(100);
      if (found || timeout || ltf_only) stray++;
    end
  endtask

  task automatic age();
    lows(70);
    stray = 0;
  endtask

  task automatic t_reset();
    check("R10 found", found, 0);
    check("R10 timeout", timeout, 0);
    check("R10 ltf_only", ltf_only, 0);
    check("R10 first_big", first_big, 0);
    check("R10 second_big", second_big, 0);
    check("R10 ltf_count", ltf_count, 0);
  endtask

  task automatic t_pair63();
    spacing_mask = 3'b001;
    age(); arm();
    smp(900); lows(62); smp(600);
    check("R3 found at 63", found, 1);
    check("R2 first big", first_big, 1);
    check("R2 second small", second_big, 0);
    check("R8 no ltf when armed", ltf_only, 0);
    smp(100);
    check("R6 found single pulse", found, 0);
    check("R6 no stray", stray, 0);
  endtask

  task automatic t_equal_thresh();
    spacing_mask = 3'b011;
    age(); arm();
    smp(800); lows(62); smp(500);
    check("R1 equal is not peak", found, 0);
    smp(801);
    check("R3 found at 64", found, 1);
    check("R2 equal class is small", first_big, 0);
    check("R2 above class is big", second_big, 1);
  endtask

  task automatic t_replace();
    spacing_mask = 3'b100;
    age(); arm();
    smp(900); lows(62); smp(900);
    check("R3 63 masked off", found, 0);
    lows(64); smp(900);
    check("R4 new reference pairs at 65", found, 1);
    check("R4 no stray", stray, 0);
  endtask

  task automatic t_far();
    spacing_mask = 3'b010;
    age(); arm();
    smp(900); lows(69); smp(900);
    check("R4 far peak no pair", found, 0);
    lows(63); smp(900);
    check("R4 far peak became reference", found, 1);
  endtask

  task automatic t_timeout();
    timeout_len = 8'd3;
    age(); arm();
    lows(5);
    check("R5 no early timeout", stray, 0);
    smp(100);
    check("R5 timeout at sample 6", timeout, 1);
    check("R6 no found with timeout", found, 0);
    smp(100);
    check("R6 timeout single pulse", timeout, 0);
    timeout_len = 8'd0;
    smp(100, 1'b1);
    check("R5 zero length times out", timeout, 1);
    timeout_len = 8'd255;
  endtask

  task automatic t_limit_pair();
    timeout_len = 8'd32;
    spacing_mask = 3'b001;
    age(); arm();
    smp(900); lows(62); smp(600);
    check("R5 pair wins on limit sample", found, 1);
    check("R5 no timeout with pair", timeout, 0);
    timeout_len = 8'd255;
  endtask

  task automatic t_req_block();
    req_pkt_det = 1'b1;
    spacing_mask = 3'b111;
    age();
    smp(900); lows(62); smp(900);
    check("R7 unarmed pair ignored", found, 0);
    arm();
    lows(63); smp(900);
    check("R7 closing peak kept as reference", found, 1);
    check("R7 counter untouched", ltf_count, 0);
  endtask

  task automatic t_ltf_only();
    req_pkt_det = 1'b0;
    spacing_mask = 3'b010;
    age();
    smp(900); lows(63); smp(900);
    check("R8 ltf found", found, 1);
    check("R8 ltf flag", ltf_only, 1);
    check("R9 count one", ltf_count, 1);
    smp(100);
    check("R8 ltf single pulse", ltf_only, 0);
    smp(900); lows(63); smp(900);
    check("R9 count two", ltf_count, 2);
    smp(100, 1'b0, 1'b1);
    check("R9 clear", ltf_count, 0);
    age();
    smp(900); lows(63); smp(900, 1'b0, 1'b1);
    check("R9 ltf pulse with clear", ltf_only, 1);
    check("R9 clear wins", ltf_count, 0);
    req_pkt_det = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_pair63();
    t_equal_thresh();
    t_replace();
    t_far();
    t_timeout();
    t_limit_pair();
    t_req_block();
    t_ltf_only();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule